// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This block turns a 32-bit integer into the bit pattern of an IEEE-754 binary32 value in a single combinational pass. A mode input picks how the source word is read: as an unsigned count, or as a two's complement signed number. The result is exact where the value fits in 24 significant bits. Otherwise it is rounded to the nearest representable value, and ties go to the even significand.

Internally the design forms the magnitude of the input with an inverter and an explicit incrementer. A leading-zero counter feeds a logarithmic left shifter, which normalizes the magnitude so its leading one sits in the top bit. The biased exponent comes from subtracting the count from a constant. The bits shifted out below the significand are gathered into guard, round and sticky bits. A small control module turns these status bits into strobes: negate, round up, bump the exponent, and force zero. All additions and subtractions in the datapath are built from explicit full-adder chains rather than arithmetic operators.

Top module: `i2f_converter`

## Requirements
- R1: An all-zero input word yields an output of 0x00000000 (positive zero) in both modes.
- R2: With `signedMode` = 0 the input is read as unsigned: output bit 31 is 0 and the value is the input rounded to binary32.
- R3: With `signedMode` = 1 and input bit 31 set, output bit 31 is 1 and the magnitude is the two's complement of the input; 0x80000000 gives 0xCF000000 and 0xFFFFFFFF gives 0xBF800000.
- R4: Output bits 30:23 hold 127 plus the bit position of the magnitude's leading one, unless rounding carries out (R7); an input of 1 gives 0x3F800000.
- R5: When the magnitude is below 2^24 the conversion is exact: bits 22:0 hold the magnitude bits below the leading one, left aligned.
- R6: When bits are dropped, the significand is raised by one exactly when the first dropped bit is 1 and either any later dropped bit is 1 or the kept significand is odd (ties to even); e.g. 0x01000001 gives 0x4B800000 and 0x01000003 gives 0x4B800002.
- R7: A rounding increment that overflows the 24-bit significand raises the exponent by one and leaves bits 22:0 zero; unsigned 0xFFFFFFFF gives 0x4F800000 and signed 0x7FFFFFFF gives 0x4F000000.
- R8: An input with bit 31 clear converts to the same pattern in both modes, and the output exponent field is never all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intIn | input | 32 | Integer source word |
| signedMode | input | 1 | 1 reads intIn as two's complement, 0 as unsigned |
| floatOut | output | 32 | binary32 pattern: sign bit 31, exponent 30:23, fraction 22:0 |

## Verification
The bench builds the converter with its default widths: 32-bit source, 8-bit exponent and 23-bit fraction. With these widths every leading-one position from 0 to 31 can be reached. So can up to eight dropped bits feeding guard, round and sticky, and the one case where rounding carries into the exponent. Directed words hit the ties in both directions, the most negative signed value and the all-ones word in both modes. Random words follow, and their expected patterns come from a reference function in the bench that uses wide integer arithmetic.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic negate;   // take two's complement of the source
    logic roundUp;  // add one to the kept significand
    logic expBump;  // add one to the exponent after rounding carry
    logic zeroOut;  // force the whole result to +0.0
    logic signOut;  // sign bit of the result
  } i2f_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic signBit;    // top bit of the source word
    logic magZero;    // magnitude is zero
    logic sigLsb;     // least significant kept significand bit
    logic guardBit;   // first dropped bit
    logic roundBit;   // second dropped bit
    logic stickyBit;  // OR of all later dropped bits
    logic roundCarry; // rounding overflowed the significand
  } i2f_status_t;

endpackage

// File: rtl/i2f_adder.sv
module i2f_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end

endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     value,
  output logic [CNT_W-1:0] count,
  output logic             allZero
);

  logic found;

  always_comb begin
    count = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && value[i]) begin
        count = CNT_W'(W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign allZero = ~|value;

endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import i2f_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W = FRAC_W + 1,
  localparam int CNT_W = $clog2(INT_W),
  localparam int OUT_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int TOP_EXP = BIAS + INT_W - 1,
  localparam int DROP_W = INT_W - SIG_W
) (
  input  logic [INT_W-1:0] intIn,
  input  i2f_strobe_t      strobe,
  output i2f_status_t      status,
  output logic [OUT_W-1:0] floatOut
);

  // Magnitude: (x ^ mask) + negate
  logic [INT_W-1:0] flipped;
  logic [INT_W-1:0] magnitude;

  assign flipped = intIn ^ {INT_W{strobe.negate}};

  i2f_adder #(.W(INT_W)) u_magAdd (
    .a  (flipped),
    .b  ('0),
    .cin(strobe.negate),
    .sum(magnitude)
  );

  // Leading-zero count
  logic [CNT_W-1:0] lzCount;
  logic             magZero;

  i2f_lzc #(.W(INT_W)) u_lzc (
    .value  (magnitude),
    .count  (lzCount),
    .allZero(magZero)
  );

  // Logarithmic normalizing shifter
  logic [INT_W-1:0] stage [CNT_W+1];

  assign stage[0] = magnitude;

  for (genvar k = 0; k < CNT_W; k++) begin : g_shift
    assign stage[k+1] = lzCount[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  logic [INT_W-1:0] normalized;
  assign normalized = stage[CNT_W];

  // Split into kept significand and dropped bits
  logic [SIG_W-1:0]  keptSig;
  logic [DROP_W-1:0] dropped;

  assign keptSig = normalized[INT_W-1 -: SIG_W];
  assign dropped = normalized[DROP_W-1:0];

  // Rounding increment, one bit wider to catch overflow
  logic [SIG_W:0] roundedSig;

  i2f_adder #(.W(SIG_W + 1)) u_roundAdd (
    .a  ({1'b0, keptSig}),
    .b  ('0),
    .cin(strobe.roundUp),
    .sum(roundedSig)
  );

  // Exponent: TOP_EXP - lzCount, as TOP_EXP + ~lz + 1
  logic [EXP_W-1:0] lzWide;
  logic [EXP_W-1:0] expRaw;
  logic [EXP_W-1:0] expFinal;

  assign lzWide = {{(EXP_W - CNT_W){1'b0}}, lzCount};

  i2f_adder #(.W(EXP_W)) u_expSub (
    .a  (EXP_W'(TOP_EXP)),
    .b  (~lzWide),
    .cin(1'b1),
    .sum(expRaw)
  );

  i2f_adder #(.W(EXP_W)) u_expBump (
    .a  (expRaw),
    .b  ('0),
    .cin(strobe.expBump),
    .sum(expFinal)
  );

  // Status to control
  assign status.signBit    = intIn[INT_W-1];
  assign status.magZero    = magZero;
  assign status.sigLsb     = keptSig[0];
  assign status.guardBit   = dropped[DROP_W-1];
  assign status.roundBit   = dropped[DROP_W-2];
  assign status.stickyBit  = |dropped[DROP_W-3:0];
  assign status.roundCarry = roundedSig[SIG_W];

  // Result assembly
  assign floatOut = strobe.zeroOut ? '0
                  : {strobe.signOut, expFinal, roundedSig[FRAC_W-1:0]};

endmodule

// File: rtl/i2f_control.sv
module i2f_control
  import i2f_pkg::*;
(
  input  logic        signedMode,
  input  i2f_status_t status,
  output i2f_strobe_t strobe
);

  logic tieOrAbove;

  // Nearest-even: raise when above half, or exactly half with odd lsb
  assign tieOrAbove = status.roundBit | status.stickyBit | status.sigLsb;

  always_comb begin
    strobe.negate  = signedMode & status.signBit;
    strobe.signOut = signedMode & status.signBit;
    strobe.zeroOut = status.magZero;
    strobe.roundUp = status.guardBit & tieOrAbove;
    strobe.expBump = status.roundCarry;
  end

endmodule

// File: rtl/i2f_converter.sv
module i2f_converter
  import i2f_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OUT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [INT_W-1:0] intIn,
  input  logic             signedMode,
  output logic [OUT_W-1:0] floatOut
);

  i2f_strobe_t strobe;
  i2f_status_t status;

  i2f_control u_ctrl (
    .signedMode(signedMode),
    .status    (status),
    .strobe    (strobe)
  );

  i2f_datapath #(
    .INT_W (INT_W),
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .intIn   (intIn),
    .strobe  (strobe),
    .status  (status),
    .floatOut(floatOut)
  );

endmodule

// File: rtl/i2f_checker.sv
module i2f_checker #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OUT_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input logic [INT_W-1:0] intIn,
  input logic             signedMode,
  input logic [OUT_W-1:0] floatOut
);

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              signField;

  assign signField = floatOut[OUT_W-1];
  assign expField  = floatOut[OUT_W-2 -: EXP_W];
  assign fracField = floatOut[FRAC_W-1:0];

  always_comb begin
    if (intIn == '0) begin
      AST_ZERO_CLEAR: assert (floatOut == '0); // R1
    end
    if (!signedMode) begin
      AST_UNSIGNED_POSITIVE: assert (!signField); // R2
    end
    if (signedMode && intIn[INT_W-1]) begin
      AST_NEGATIVE_SIGN: assert (signField); // R3
    end
    if (intIn != '0) begin
      AST_EXP_WINDOW: assert (expField >= EXP_W'(BIAS) && expField <= EXP_W'(BIAS + INT_W)); // R4
    end
    if (!signedMode && $onehot0(intIn) && intIn != '0) begin
      AST_POW2_EXACT: assert (fracField == '0); // R5
    end
    AST_NO_SPECIAL_EXP: assert (expField != '1); // R8
  end

endmodule

bind i2f_converter i2f_checker #(
  .INT_W (INT_W),
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .intIn     (intIn),
  .signedMode(signedMode),
  .floatOut  (floatOut)
);

// File: tb/tb_i2f_converter.sv
module tb_i2f_converter;

  logic        clk = 1'b0;
  logic [31:0] intIn = '0;
  logic        signedMode = 1'b0;
  logic [31:0] floatOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  i2f_converter dut (
    .intIn     (intIn),
    .signedMode(signedMode),
    .floatOut  (floatOut)
  );

  function automatic logic [31:0] refConv(input logic [31:0] v, input bit s);
    bit neg;
    longint unsigned m, sig, rem, half;
    int p, sh, e;
    neg = s && v[31];
    m = neg ? (64'h1_0000_0000 - longint'(v)) : longint'(v);
    if (m == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 33; i++) if (m[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      sig = m << (23 - p);
    end else begin
      sh = p - 23;
      sig = m >> sh;
      rem = m & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && sig[0])) sig = sig + 1;
      if (sig == (64'd1 << 24)) begin
        sig = sig >> 1;
        e = e + 1;
      end
    end
    return {neg, e[7:0], sig[22:0]};
  endfunction

  task automatic check(input logic [31:0] v, input bit s, input string req);
    logic [31:0] exp;
    @(negedge clk);
    intIn = v;
    signedMode = s;
    #1;
    exp = refConv(v, s);
    checks++;
    if (floatOut !== exp) begin
      fails++;
      $display("FAIL %s in=%08h signed=%0d got=%08h expected=%08h", req, v, s, floatOut, exp);
    end
  endtask

  task automatic checkFixed(input logic [31:0] v, input bit s, input logic [31:0] exp, input string req);
    @(negedge clk);
    intIn = v;
    signedMode = s;
    #1;
    checks++;
    if (floatOut !== exp) begin
      fails++;
      $display("FAIL %s in=%08h signed=%0d got=%08h expected=%08h", req, v, s, floatOut, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] a, b;
    void'($urandom(32'd2024));
    // Directed corners
    checkFixed(32'h0000_0000, 1'b0, 32'h0000_0000, "R1");
    checkFixed(32'h0000_0000, 1'b1, 32'h0000_0000, "R1");
    checkFixed(32'h0000_0001, 1'b0, 32'h3F80_0000, "R4");
    checkFixed(32'h8000_0000, 1'b0, 32'h4F00_0000, "R2");
    checkFixed(32'h8000_0000, 1'b1, 32'hCF00_0000, "R3");
    checkFixed(32'hFFFF_FFFF, 1'b1, 32'hBF80_0000, "R3");
    checkFixed(32'hFFFF_FFFF, 1'b0, 32'h4F80_0000, "R7");
    checkFixed(32'h7FFF_FFFF, 1'b1, 32'h4F00_0000, "R7");
    checkFixed(32'h00FF_FFFF, 1'b0, 32'h4B7F_FFFF, "R5");
    checkFixed(32'h0001_2345, 1'b1, 32'h4791_A280, "R5");
    checkFixed(32'h0100_0001, 1'b0, 32'h4B80_0000, "R6");
    checkFixed(32'h0100_0003, 1'b0, 32'h4B80_0002, "R6");
    checkFixed(32'h0100_0005, 1'b1, 32'h4B80_0002, "R6");
    // Same word, both modes, top bit clear
    a = 32'h1234_5678;
    check(a, 1'b0, "R8");
    b = floatOut;
    check(a, 1'b1, "R8");
    checks++;
    if (floatOut !== b) begin
      fails++;
      $display("FAIL R8 mode mismatch got=%08h expected=%08h", floatOut, b);
    end
    // Every leading-one position, both modes
    for (int p = 0; p < 32; p++) begin
      check(32'h1 << p, 1'b0, "R4");
      check((32'h1 << p) | 32'h0000_00FF, 1'b1, "R6");
    end
    // Random
    for (int i = 0; i < 3000; i++) begin
      a = $urandom;
      case (i % 4)
        0: a = a >> ($urandom % 32);
        1: a = a | 32'h8000_0000;
        default: ;
      endcase
      check(a, i[0], i[0] ? "R3" : "R2");
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule